// File: doc/BRIEF.md
# Buffered SPI Host Controller

This block is a full-duplex SPI host for one word width. Software hands it a word through a transmit write port. The word lands in a transmit holding register and moves to a single shift register as soon as the bus is free. The shift register clocks the word out on MOSI and, at the same time, fills with the bits it samples from MISO. When a word completes, the received bits go into a receive holding register. A word that was written while the bus was busy is then started automatically, so a steady stream needs only one write per word.

A divider sets the serial clock period. The clock runs in mode 0: it idles low, MISO is sampled on the rising edge and MOSI changes on the falling edge. Words go out most significant bit first. One of several chip-select lines is driven low for the duration of the activity. A programmable idle gap, counted in system clocks, follows every word. An optional stall mode holds back each new word until the previous received word has been read.

Four live status outputs describe the block: transmit holding free, fully idle, receive holding full and receive overrun.

Top module: `spi_host_buf`

## Requirements
- R1: After reset with `en` high, `tx_free` and `tx_idle` are 1, `rx_full` and `rx_overrun` are 0, all of `cs_n` are 1 and `sck` is 0.
- R2: While `en` is low, `tx_free` and `tx_idle` read 0, receive state is cleared, and `tx_wr` is ignored: no chip select is asserted and `sck` stays low.
- R3: A write to an idle block drops `tx_free` on the cycle after the write and raises it again one cycle later, when the word enters the shift register. Bits leave on `mosi` most significant first and change only on falling `sck` edges.
- R4: `sck` has half-periods of (max(`div`,1)+1) system clocks. The selected chip select falls exactly one half-period before the first rising `sck` edge.
- R5: During a transfer only `cs_n[psel]` is low, where `psel` is the value captured when the word was loaded. All other lines stay high.
- R6: A write made during a transfer is held with `tx_free` at 0. With a zero gap and stall mode off, the held word starts at the edge where the current word ends, and chip select does not rise in between.
- R7: `miso` is sampled on each rising `sck` edge, most significant bit first. At word end the assembled word appears on `rx_data` and `rx_full` sets. A `rx_rd` pulse clears `rx_full`.
- R8: If a word ends while `rx_full` is set and no `rx_rd` occurs in that cycle, `rx_overrun` sets and `rx_data` still takes the new word. `rx_rd` leaves `rx_overrun` unchanged, and only a `stat_rd` pulse clears it.
- R9: With `rd_stall` high, a pending word does not start while `rx_full` is set. It starts after `rx_full` is cleared by a read. Chip select is released while the word waits.
- R10: After every word the block waits `gap` system clocks before it starts the next word or goes idle. `tx_idle` rises, and chip select rises, exactly `gap` clocks after the final falling `sck` edge.
- R11: A `div` value of 0 behaves exactly as 1, so the half-period is 2 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; low holds everything cleared |
| rd_stall | input | 1 | Hold each new word until received data is read |
| psel | input | 2 | Index of the chip-select line for the next word |
| div | input | 8 | Serial clock divider (half-period = max(div,1)+1 clocks) |
| gap | input | 8 | Idle clocks inserted after each word |
| tx_wr | input | 1 | One-cycle transmit write strobe |
| tx_data | input | 8 | Transmit word |
| rx_rd | input | 1 | One-cycle receive read strobe |
| rx_data | output | 8 | Receive holding register |
| stat_rd | input | 1 | One-cycle status read strobe; clears overrun |
| tx_free | output | 1 | Transmit holding register can accept a word |
| tx_idle | output | 1 | No word in flight, in gap or pending |
| rx_full | output | 1 | Unread word in the receive holding register |
| rx_overrun | output | 1 | A word was overwritten before it was read |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects |

## Verification
The bench measures the lead time from chip select to the first clock edge and the half-period widths, both for a divider of zero and for larger dividers. A counter that is off by one would show up there as a skew of 20 ns or more. It chains two words and watches that chip select never rises between them. A design that returns to idle between words, or overwrites the held word, would drop the select line or lose a byte from the scoreboard. It fills the receive register twice without a read and then checks three things: the overrun flag survives a data read, the flag clears on a status read, and the newest word is the one kept. A design that kept the old word, or cleared overrun on a data read, fails these checks. Finally, it leaves a second word pending in stall mode and confirms that nothing moves until the read, and that the idle flag appears exactly `gap` clocks after the last word.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_GAP  = 2'd2
    } xfer_state_e;

    typedef struct packed {
        logic tx_free;
        logic tx_idle;
        logic rx_full;
        logic rx_overrun;
    } host_flags_t;

    function automatic int sel_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/spi_sck_gen.sv
module spi_sck_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             sck,
    output logic             rise_p,
    output logic             fall_p
);
    logic [DIV_W-1:0] div_eff;
    logic [DIV_W-1:0] half_cnt;
    logic             half_end;

    // zero divider is clamped so a half-period is never shorter than 2 clocks
    assign div_eff  = (div == '0) ? DIV_W'(1) : div;
    assign half_end = run && (half_cnt >= div_eff);
    assign rise_p   = half_end && !sck;
    assign fall_p   = half_end && sck;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            half_cnt <= '0;
            sck      <= 1'b0;
        end else if (half_end) begin
            half_cnt <= '0;
            sck      <= ~sck;
        end else begin
            half_cnt <= half_cnt + DIV_W'(1);
        end
    end

    // R4: the serial clock is parked low whenever no word is in flight
    assert_sck_parked_R4: assert property (@(posedge clk) disable iff (rst)
        !run |=> !sck);

endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              rise_p,
    input  logic              fall_p,
    input  logic              miso,
    output logic              mosi_bit,
    output logic              done,
    output logic [DATA_W-1:0] rx_word
);
    localparam int CNT_W = $clog2(DATA_W);

    logic [DATA_W-1:0] sr;
    logic              samp;
    logic [CNT_W-1:0]  bit_cnt;

    assign mosi_bit = sr[DATA_W-1];
    assign done     = fall_p && (bit_cnt == CNT_W'(DATA_W-1));
    assign rx_word  = {sr[DATA_W-2:0], samp};

    always_ff @(posedge clk) begin
        if (rst) begin
            sr      <= '0;
            samp    <= 1'b0;
            bit_cnt <= '0;
        end else if (load) begin
            sr      <= load_data;
            bit_cnt <= '0;
        end else begin
            if (rise_p) samp <= miso;
            if (fall_p) begin
                sr      <= rx_word;
                bit_cnt <= bit_cnt + CNT_W'(1);
            end
        end
    end

    // R3: outgoing data never moves across a rising serial edge
    assert_mosi_hold_R3: assert property (@(posedge clk) disable iff (rst)
        rise_p |=> $stable(mosi_bit));

endmodule

// File: rtl/spi_host_buf.sv
module spi_host_buf
    import spi_host_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8,
    parameter int DLY_W  = 8,
    parameter int NCS    = 4,
    localparam int SEL_W = sel_width(NCS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              rd_stall,
    input  logic [SEL_W-1:0]  psel,
    input  logic [DIV_W-1:0]  div,
    input  logic [DLY_W-1:0]  gap,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_data,
    input  logic              stat_rd,
    output logic              tx_free,
    output logic              tx_idle,
    output logic              rx_full,
    output logic              rx_overrun,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [NCS-1:0]    cs_n
);
    xfer_state_e       state, state_nx;
    logic [DATA_W-1:0] tx_hold, rx_hold;
    logic              pending, rdrf_q, ovr_q;
    logic [SEL_W-1:0]  cs_sel;
    logic [DLY_W-1:0]  gap_cnt;
    logic              run, load, rise_p, fall_p, done, mosi_bit, start_ok;
    logic [DATA_W-1:0] rx_word;
    host_flags_t       flags;

    assign run      = (state == ST_XFER);
    assign start_ok = pending && !(rd_stall && rdrf_q);

    spi_sck_gen #(.DIV_W(DIV_W)) u_sck (
        .clk(clk), .rst(rst), .run(run), .div(div),
        .sck(sck), .rise_p(rise_p), .fall_p(fall_p)
    );

    spi_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst(rst), .load(load), .load_data(tx_hold),
        .rise_p(rise_p), .fall_p(fall_p), .miso(miso),
        .mosi_bit(mosi_bit), .done(done), .rx_word(rx_word)
    );

    // sequencing: every load comes from the holding register
    always_comb begin
        load     = 1'b0;
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start_ok) begin
                load     = 1'b1;
                state_nx = ST_XFER;
            end
            ST_XFER: if (done) begin
                if (gap != '0)                  state_nx = ST_GAP;
                else if (pending && !rd_stall)  load = 1'b1;
                else                            state_nx = ST_IDLE;
            end
            ST_GAP: if (gap_cnt == '0) begin
                if (start_ok) begin
                    load     = 1'b1;
                    state_nx = ST_XFER;
                end else begin
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
        if (!en) begin
            load     = 1'b0;
            state_nx = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state   <= ST_IDLE;
            pending <= 1'b0;
            tx_hold <= '0;
            rx_hold <= '0;
            rdrf_q  <= 1'b0;
            ovr_q   <= 1'b0;
            cs_sel  <= '0;
            gap_cnt <= '0;
        end else begin
            state <= state_nx;
            if (tx_wr) begin
                tx_hold <= tx_data;
                pending <= 1'b1;
            end else if (load) begin
                pending <= 1'b0;
            end
            if (load) cs_sel <= psel;
            if (run && done && gap != '0)
                gap_cnt <= gap - DLY_W'(1);
            else if (state == ST_GAP && gap_cnt != '0)
                gap_cnt <= gap_cnt - DLY_W'(1);
            if (done) begin
                rx_hold <= rx_word;
                rdrf_q  <= 1'b1;
            end else if (rx_rd) begin
                rdrf_q  <= 1'b0;
            end
            if (done && rdrf_q && !rx_rd) ovr_q <= 1'b1;
            else if (stat_rd)             ovr_q <= 1'b0;
        end
    end

    always_comb begin
        flags.tx_free    = en && !pending;
        flags.tx_idle    = en && (state == ST_IDLE) && !pending;
        flags.rx_full    = rdrf_q;
        flags.rx_overrun = ovr_q;
    end

    assign tx_free    = flags.tx_free;
    assign tx_idle    = flags.tx_idle;
    assign rx_full    = flags.rx_full;
    assign rx_overrun = flags.rx_overrun;
    assign rx_data    = rx_hold;
    assign mosi       = run ? mosi_bit : 1'b0;

    for (genvar i = 0; i < NCS; i++) begin : g_cs
        assign cs_n[i] = !((state != ST_IDLE) && (cs_sel == SEL_W'(i)));
    end

    assert_free_drops_R3: assert property (@(posedge clk) disable iff (rst)
        (en && tx_wr) |=> !tx_free);
    assert_one_select_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));
    assert_rx_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (en && rx_rd && !done) |=> !rx_full);
    assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (en && rx_overrun && !stat_rd) |=> rx_overrun);
    assert_stall_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_stall && rdrf_q && !run) |=> !run);
    assert_chain_R6: assert property (@(posedge clk) disable iff (rst)
        (en && run && done && pending && !rd_stall && gap == '0) |=> run);
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        tx_idle |-> ((&cs_n) && !sck));

endmodule

// File: tb/sim_spi_host_buf.sv
`timescale 1ns/1ps
module sim_spi_host_buf;
    localparam int T = 20;

    logic       clk = 1'b0, rst = 1'b1, en = 1'b0, rd_stall = 1'b0;
    logic       tx_wr = 1'b0, rx_rd = 1'b0, stat_rd = 1'b0;
    logic [1:0] psel = 2'd0;
    logic [7:0] div = 8'd1, gap = 8'd0, tx_data = 8'd0;
    logic [7:0] rx_data;
    logic       tx_free, tx_idle, rx_full, rx_overrun, sck, mosi, miso;
    logic [3:0] cs_n;

    always #10 clk = ~clk;

    spi_host_buf u0 (
        .clk(clk), .rst(rst), .en(en), .rd_stall(rd_stall), .psel(psel),
        .div(div), .gap(gap), .tx_wr(tx_wr), .tx_data(tx_data),
        .rx_rd(rx_rd), .rx_data(rx_data), .stat_rd(stat_rd),
        .tx_free(tx_free), .tx_idle(tx_idle), .rx_full(rx_full),
        .rx_overrun(rx_overrun), .sck(sck), .mosi(mosi), .miso(miso),
        .cs_n(cs_n)
    );

    int  checks = 0, errors = 0;
    bit  finished = 0;

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        end
        $finish;
    endtask

    // peripheral model and scoreboard
    logic [7:0] tx_q[$];
    logic [3:0] exp_cs = 4'hF;
    int         bit_idx = 0, done_cnt = 0;
    logic [7:0] in_byte = 8'h00, cur_rx, last_rx = 8'h00;
    time        t_done = 0;

    function automatic logic [7:0] rx_pat(input int k);
        return 8'h3C + 8'(k * 29);
    endfunction

    initial cur_rx = rx_pat(0);
    assign miso = cur_rx[7 - bit_idx];

    always @(posedge sck) begin
        in_byte = {in_byte[6:0], mosi};
        check("R5", {28'd0, cs_n}, {28'd0, exp_cs}, "select at rising edge");
    end

    always @(negedge sck) begin
        bit_idx++;
        if (bit_idx == 8) begin
            bit_idx = 0;
            if (tx_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R3 unexpected word: actual %0h expected none", in_byte);
            end else begin
                check("R3", {24'd0, in_byte}, {24'd0, tx_q.pop_front()}, "MOSI word");
            end
            last_rx = cur_rx;
            done_cnt++;
            cur_rx = rx_pat(done_cnt);
            t_done = $time;
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_raw(input logic [7:0] d);
        tx_data = d; tx_wr = 1'b1; tick(); tx_wr = 1'b0;
    endtask

    task automatic send(input logic [7:0] d);
        tx_q.push_back(d);
        exp_cs = ~(4'b0001 << psel);
        write_raw(d);
    endtask

    task automatic read_rx(input string req);
        check(req, {24'd0, rx_data}, {24'd0, last_rx}, "received word");
        rx_rd = 1'b1; tick(); rx_rd = 1'b0;
    endtask

    task automatic clear_status();
        stat_rd = 1'b1; tick(); stat_rd = 1'b0;
    endtask

    task automatic wait_idle();
        while (!tx_idle) tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL R3 watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        time t0, t1, t2;
        int  n, cs_gaps;
        tick(3); rst = 1'b0; tick();

        // R2: disabled block ignores writes
        check("R2", {31'd0, tx_free}, 32'd0, "free while disabled");
        check("R2", {31'd0, tx_idle}, 32'd0, "idle while disabled");
        write_raw(8'h5A);
        tick(40);
        check("R2", {28'd0, cs_n}, 32'hF, "no select while disabled");
        check("R2", {31'd0, sck}, 32'd0, "no clock while disabled");

        // R1: state after enable
        en = 1'b1; tick();
        check("R1", {31'd0, tx_free}, 32'd1, "free after enable");
        check("R1", {31'd0, tx_idle}, 32'd1, "idle after enable");
        check("R1", {31'd0, rx_full}, 32'd0, "rx empty after enable");
        check("R1", {31'd0, rx_overrun}, 32'd0, "no overrun after enable");
        check("R1", {28'd0, cs_n}, 32'hF, "selects high after enable");

        // single word, div 1 (half = 2 clocks)
        psel = 2'd2; div = 8'd1; gap = 8'd0;
        send(8'hC3);
        check("R3", {31'd0, tx_free}, 32'd0, "free drops after write");
        wait (cs_n != 4'hF); t0 = $time;
        @(posedge sck); t1 = $time;
        @(negedge sck); t2 = $time;
        check("R4", 32'(t1 - t0), 32'(2 * T), "lead time div1");
        check("R4", 32'(t2 - t1), 32'(2 * T), "high half div1");
        tick();
        check("R3", {31'd0, tx_free}, 32'd1, "free again after load");
        wait_idle();
        check("R10", {28'd0, cs_n}, 32'hF, "select released at idle");
        check("R7", {31'd0, rx_full}, 32'd1, "rx full after word");
        read_rx("R7");
        check("R7", {31'd0, rx_full}, 32'd0, "rx cleared by read");

        // R11: divider zero
        div = 8'd0; psel = 2'd0;
        send(8'h96);
        wait (cs_n != 4'hF); t0 = $time;
        @(posedge sck); t1 = $time;
        @(negedge sck); t2 = $time;
        check("R11", 32'(t1 - t0), 32'(2 * T), "lead time div0");
        check("R11", 32'(t2 - t1), 32'(2 * T), "high half div0");
        tick(); wait_idle(); read_rx("R7");

        // R6 + R8: chained words, overrun
        div = 8'd3; psel = 2'd1;
        send(8'h0F);
        wait (cs_n != 4'hF); t0 = $time;
        @(posedge sck); t1 = $time;
        check("R4", 32'(t1 - t0), 32'(4 * T), "lead time div3");
        tick();
        send(8'hE1);
        tick(2);
        check("R6", {31'd0, tx_free}, 32'd0, "word held during transfer");
        cs_gaps = 0;
        while (!tx_idle) begin
            if (cs_n[1]) cs_gaps++;
            tick();
        end
        check("R6", 32'(cs_gaps), 32'd0, "select held across chained words");
        check("R8", {31'd0, rx_overrun}, 32'd1, "overrun set");
        check("R8", {31'd0, rx_full}, 32'd1, "rx still full");
        read_rx("R8");
        check("R8", {31'd0, rx_overrun}, 32'd1, "overrun survives data read");
        clear_status();
        check("R8", {31'd0, rx_overrun}, 32'd0, "overrun cleared by status read");

        // R10: gap before idle
        div = 8'd1; psel = 2'd0; gap = 8'd7;
        send(8'h81);
        @(posedge tx_idle);
        check("R10", 32'($time - t_done), 32'(7 * T), "idle after gap");
        check("R10", {28'd0, cs_n}, 32'hF, "select released after gap");
        tick(); read_rx("R7");

        // R10: gap between consecutive words
        gap = 8'd5;
        n = done_cnt;
        send(8'h42); tick(4); send(8'h24);
        wait (done_cnt == n + 1); t0 = t_done;
        @(posedge sck);
        check("R10", 32'($time - t0), 32'((5 + 2) * T), "gap then lead before next word");
        tick(); wait_idle();
        clear_status(); read_rx("R7");

        // R9: stall until read
        gap = 8'd0; rd_stall = 1'b1; psel = 2'd3;
        n = done_cnt;
        send(8'h77); tick(3); send(8'h88);
        wait (done_cnt == n + 1); tick(); tick(60);
        check("R9", 32'(done_cnt), 32'(n + 1), "second word stalled");
        check("R9", {28'd0, cs_n}, 32'hF, "select released while stalled");
        check("R9", {31'd0, tx_free}, 32'd0, "word still pending");
        check("R9", {31'd0, tx_idle}, 32'd0, "not idle while pending");
        read_rx("R9");
        wait_idle();
        check("R9", 32'(done_cnt), 32'(n + 2), "second word after read");
        read_rx("R9");
        rd_stall = 1'b0;

        check("R3", 32'(tx_q.size()), 32'd0, "scoreboard drained");
        summary();
    end
endmodule